// File: doc/BRIEF.md
# Doorbell and Data-Window Outbound Translator

This block sits on the inbound write path of one side of a two-host bridge. It serves a single window in which the doorbells come first and the first data window follows, split at a programmable offset. A write that lands in the doorbell area rings one doorbell. The block turns it into an outbound interrupt write: the interrupt address programmed for that doorbell, carrying the data word stored for it. The data the host wrote is ignored. Every doorbell has its own address entry. A host that hands out one shared address for all vectors (MSI) and a host that hands out one address per vector (MSI-X) are therefore served by the same path.

A write at or beyond the split offset goes to the data window. The offset relative to the split is added to a 64-bit base that the far host programmed. Writes beyond the programmed window size, doorbells beyond the configured doorbell count, and any access to a region whose configure step has not yet finished are dropped with a one-cycle error pulse. All configuration comes from the command engine as static inputs. The output is a plain address/data write request under a valid/ready handshake. It produces one result per accepted input, in order.

Top module: `ntb_db_win_xlat`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid` and `err_drop` are low; `in_ready` is high once reset ends.
- R2: A write with `in_off < cfg_mw_off` goes to the doorbell area. A write with `in_off >= cfg_mw_off` goes to the data window. `out_is_db` is 1 for a doorbell request and 0 for a window request.
- R3: A doorbell entry is 2^`cfg_db_shift` bytes wide. The doorbell index is `in_off >> cfg_db_shift`, so an offset inside an entry rounds down to that entry. The request carries address entry `idx` of `cfg_db_addr` (bits idx*64 and up) and data word `idx` of `cfg_db_data` (bits idx*32 and up). `in_data` is ignored.
- R4: The address entries are used per index. Identical entries (one shared interrupt address) and distinct entries (one address per vector) both give each doorbell its own programmed entry.
- R5: A doorbell write whose index is at or beyond `cfg_db_count` (at most NDB = 32) is dropped: no request, and `err_drop` pulses.
- R6: A window write produces the address `cfg_mw_base + (in_off - cfg_mw_off)` and carries `in_data`.
- R7: A window write with `in_off - cfg_mw_off >= cfg_mw_size` is dropped with an `err_drop` pulse.
- R8: While `cfg_db_en` is 0, every doorbell-area write is dropped with an `err_drop` pulse. While `cfg_mw_en` is 0, every window write is dropped the same way.
- R9: An input is accepted on a rising edge with `in_valid` and `in_ready` both high. After that same edge, exactly one of `out_valid` and `err_drop` is high for it. `in_ready` is high when no request is held or `out_ready` is high. Nothing appears without an accepted input.
- R10: While `out_valid` is high and `out_ready` is low, the request holds with its address, data and flag unchanged. Requests leave in the order their inputs were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound write present |
| in_ready | output | 1 | Inbound write can be taken |
| in_off | input | OFF_W | Byte offset of the write within the window |
| in_data | input | 32 | Data of the inbound write |
| out_valid | output | 1 | Translated request present |
| out_ready | input | 1 | Downstream takes the request |
| out_addr | output | 64 | Translated target address |
| out_data | output | 32 | Data of the translated request |
| out_is_db | output | 1 | 1 for an interrupt (doorbell) request, 0 for a window request |
| err_drop | output | 1 | One-cycle pulse: the accepted write was dropped |
| cfg_db_en | input | 1 | Doorbell configuration finished |
| cfg_db_shift | input | SH_W | log2 of the doorbell entry size in bytes |
| cfg_db_count | input | CNT_W | Number of configured doorbells |
| cfg_db_addr | input | NDB*64 | Interrupt address for each doorbell, entry i at bits i*64 |
| cfg_db_data | input | NDB*32 | Interrupt data for each doorbell, word i at bits i*32 |
| cfg_mw_en | input | 1 | Data-window configuration finished |
| cfg_mw_off | input | OFF_W | Offset where the data window starts |
| cfg_mw_base | input | 64 | Target base address of the data window |
| cfg_mw_size | input | SIZE_W | Size of the data window in bytes |

## Verification
Every result, whether a request or an error pulse, is due one cycle after the rising edge that accepts its input. A held request stays on the outputs until the edge at which `out_ready` is high. The bench drives its inputs just after a rising edge and samples everything at the falling edge. It queues the expected result at the falling edge before the accepting edge. At the next falling edge it demands either the error pulse or a presented request. A request is compared with the head of the queue only in the cycle in which the handshake will complete. Configuration changes only while the pipe is empty, so each expected value uses the configuration that was in force at its acceptance.

// File: rtl/ntb_xlat_pkg.sv
package ntb_xlat_pkg;

    localparam int ADDR_W = 64;
    localparam int WORD_W = 32;

    // Outcome of translating one inbound write
    typedef enum logic [1:0] {
        XV_SEND     = 2'd0,
        XV_RANGE    = 2'd1,
        XV_INACTIVE = 2'd2
    } xverd_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic              is_db;
    } out_req_t;

    typedef struct packed {
        xverd_t   verd;
        out_req_t req;
    } xres_t;

    function automatic logic verd_drops(input xverd_t v);
        return v != XV_SEND;
    endfunction

endpackage

// File: rtl/ntb_db_path.sv
module ntb_db_path
    import ntb_xlat_pkg::*;
#(
    parameter int NDB   = 32,
    parameter int OFF_W = 20,
    parameter int SH_W  = 5,
    parameter int CNT_W = 6
) (
    input  logic [OFF_W-1:0]      off,
    input  logic                  en,
    input  logic [SH_W-1:0]       shift,
    input  logic [CNT_W-1:0]      count,
    input  logic [NDB*ADDR_W-1:0] addr_flat,
    input  logic [NDB*WORD_W-1:0] data_flat,
    output xres_t                 res
);
    localparam int IDX_W = (NDB > 1) ? $clog2(NDB) : 1;

    logic [ADDR_W-1:0] addr_tab [NDB];
    logic [WORD_W-1:0] data_tab [NDB];

    // Split the flat configuration buses into per-doorbell entries
    generate
        for (genvar g = 0; g < NDB; g++) begin : g_entry
            assign addr_tab[g] = addr_flat[g*ADDR_W +: ADDR_W];
            assign data_tab[g] = data_flat[g*WORD_W +: WORD_W];
        end
    endgenerate

    logic [OFF_W-1:0] idx_full;
    logic [IDX_W-1:0] idx_sel;
    logic             in_count;

    always_comb begin
        idx_full = off >> shift;
        idx_sel  = idx_full[IDX_W-1:0];
        in_count = idx_full < OFF_W'(count);
    end

    always_comb begin
        res.req.is_db = 1'b1;
        res.req.addr  = '0;
        res.req.data  = '0;
        if (in_count) begin
            res.req.addr = addr_tab[idx_sel];
            res.req.data = data_tab[idx_sel];
        end
        if (!en)
            res.verd = XV_INACTIVE;
        else if (!in_count)
            res.verd = XV_RANGE;
        else
            res.verd = XV_SEND;
    end

endmodule

// File: rtl/ntb_win_path.sv
module ntb_win_path
    import ntb_xlat_pkg::*;
#(
    parameter int OFF_W  = 20,
    parameter int SIZE_W = 32
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [WORD_W-1:0] data,
    input  logic              en,
    input  logic [OFF_W-1:0]  win_start,
    input  logic [ADDR_W-1:0] base,
    input  logic [SIZE_W-1:0] size,
    output xres_t             res
);
    logic [OFF_W-1:0] rel;
    logic             in_size;

    always_comb begin
        rel     = off - win_start;
        in_size = ADDR_W'(rel) < ADDR_W'(size);
    end

    always_comb begin
        res.req.is_db = 1'b0;
        res.req.addr  = base + ADDR_W'(rel);
        res.req.data  = data;
        if (!en)
            res.verd = XV_INACTIVE;
        else if (!in_size)
            res.verd = XV_RANGE;
        else
            res.verd = XV_SEND;
    end

endmodule

// File: rtl/ntb_req_stage.sv
module ntb_req_stage
    import ntb_xlat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  xres_t    res,
    input  logic     out_ready,
    output logic     room,
    output logic     out_valid,
    output out_req_t out_req,
    output logic     err_pulse
);
    logic drop;

    always_comb begin
        drop = verd_drops(res.verd);
        room = !out_valid || out_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= take && drop;
            if (take)
                out_valid <= !drop;
            else if (out_ready)
                out_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (take && !drop)
            out_req <= res.req;
    end

endmodule

// File: rtl/ntb_db_win_xlat.sv
module ntb_db_win_xlat
    import ntb_xlat_pkg::*;
#(
    parameter int NDB    = 32,
    parameter int OFF_W  = 20,
    parameter int SIZE_W = 32,
    localparam int SH_W  = $clog2(OFF_W),
    localparam int CNT_W = $clog2(NDB + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [OFF_W-1:0]      in_off,
    input  logic [31:0]           in_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [63:0]           out_addr,
    output logic [31:0]           out_data,
    output logic                  out_is_db,
    output logic                  err_drop,
    input  logic                  cfg_db_en,
    input  logic [SH_W-1:0]       cfg_db_shift,
    input  logic [CNT_W-1:0]      cfg_db_count,
    input  logic [NDB*64-1:0]     cfg_db_addr,
    input  logic [NDB*32-1:0]     cfg_db_data,
    input  logic                  cfg_mw_en,
    input  logic [OFF_W-1:0]      cfg_mw_off,
    input  logic [63:0]           cfg_mw_base,
    input  logic [SIZE_W-1:0]     cfg_mw_size
);
    xres_t    db_res;
    xres_t    win_res;
    xres_t    sel_res;
    out_req_t held;
    logic     in_db_area;
    logic     take;

    ntb_db_path #(
        .NDB   (NDB),
        .OFF_W (OFF_W),
        .SH_W  (SH_W),
        .CNT_W (CNT_W)
    ) u_db (
        .off       (in_off),
        .en        (cfg_db_en),
        .shift     (cfg_db_shift),
        .count     (cfg_db_count),
        .addr_flat (cfg_db_addr),
        .data_flat (cfg_db_data),
        .res       (db_res)
    );

    ntb_win_path #(
        .OFF_W  (OFF_W),
        .SIZE_W (SIZE_W)
    ) u_win (
        .off       (in_off),
        .data      (in_data),
        .en        (cfg_mw_en),
        .win_start (cfg_mw_off),
        .base      (cfg_mw_base),
        .size      (cfg_mw_size),
        .res       (win_res)
    );

    always_comb begin
        in_db_area = in_off < cfg_mw_off;
        sel_res    = in_db_area ? db_res : win_res;
        take       = in_valid && in_ready;
    end

    ntb_req_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .res       (sel_res),
        .out_ready (out_ready),
        .room      (in_ready),
        .out_valid (out_valid),
        .out_req   (held),
        .err_pulse (err_drop)
    );

    assign out_addr  = held.addr;
    assign out_data  = held.data;
    assign out_is_db = held.is_db;

endmodule

// File: rtl/ntb_db_win_xlat_chk.sv
module ntb_db_win_xlat_chk #(
    parameter int OFF_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [OFF_W-1:0] in_off,
    input logic             out_valid,
    input logic             out_ready,
    input logic [63:0]      out_addr,
    input logic [31:0]      out_data,
    input logic             out_is_db,
    input logic             err_drop,
    input logic             cfg_db_en,
    input logic             cfg_mw_en,
    input logic [OFF_W-1:0] cfg_mw_off
);
    // R1: idle directly after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> !out_valid && !err_drop);

    // R9: each accepted input yields exactly one result next cycle
    a_r9_one_result: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid ^ err_drop);

    // R9: no result without an accepted input or a held request
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) && !(out_valid && !out_ready)
        |=> !out_valid && !err_drop);

    // R10: a stalled request holds its contents
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready
        |=> out_valid && $stable(out_addr) && $stable(out_data) && $stable(out_is_db));

    // R8: nothing is translated while neither region is configured
    a_r8_inactive_drop: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !cfg_db_en && !cfg_mw_en |=> err_drop);

    // R2: the area below the split yields only interrupt requests
    a_r2_db_area: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (in_off < cfg_mw_off) |=> !out_valid || out_is_db);

    // R2: the area at or above the split yields only window requests
    a_r2_win_area: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (in_off >= cfg_mw_off) |=> !out_valid || !out_is_db);

endmodule

bind ntb_db_win_xlat ntb_db_win_xlat_chk #(.OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_off     (in_off),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_addr   (out_addr),
    .out_data   (out_data),
    .out_is_db  (out_is_db),
    .err_drop   (err_drop),
    .cfg_db_en  (cfg_db_en),
    .cfg_mw_en  (cfg_mw_en),
    .cfg_mw_off (cfg_mw_off)
);

// File: tb/sim_ntb_db_win_xlat.sv
`timescale 1ns/1ps
module sim_ntb_db_win_xlat;
    localparam int NDB    = 32;
    localparam int OFF_W  = 20;
    localparam int SIZE_W = 32;
    localparam int SH_W   = $clog2(OFF_W);
    localparam int CNT_W  = $clog2(NDB + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [OFF_W-1:0]  in_off = '0;
    logic [31:0]       in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [63:0]       out_addr;
    logic [31:0]       out_data;
    logic              out_is_db;
    logic              err_drop;
    logic              cfg_db_en = 1'b0;
    logic [SH_W-1:0]   cfg_db_shift = 5'd2;
    logic [CNT_W-1:0]  cfg_db_count = 6'd8;
    logic [NDB*64-1:0] cfg_db_addr;
    logic [NDB*32-1:0] cfg_db_data;
    logic              cfg_mw_en = 1'b0;
    logic [OFF_W-1:0]  cfg_mw_off = 20'h01000;
    logic [63:0]       cfg_mw_base = 64'h0000_00AB_C000_0000;
    logic [SIZE_W-1:0] cfg_mw_size = 32'h800;

    logic [63:0] db_addr [NDB];
    logic [31:0] db_dat  [NDB];

    always_comb begin
        for (int i = 0; i < NDB; i++) begin
            cfg_db_addr[i*64 +: 64] = db_addr[i];
            cfg_db_data[i*32 +: 32] = db_dat[i];
        end
    end

    ntb_db_win_xlat #(.NDB(NDB), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_off(in_off), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_data(out_data), .out_is_db(out_is_db),
        .err_drop(err_drop),
        .cfg_db_en(cfg_db_en), .cfg_db_shift(cfg_db_shift), .cfg_db_count(cfg_db_count),
        .cfg_db_addr(cfg_db_addr), .cfg_db_data(cfg_db_data),
        .cfg_mw_en(cfg_mw_en), .cfg_mw_off(cfg_mw_off),
        .cfg_mw_base(cfg_mw_base), .cfg_mw_size(cfg_mw_size)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    logic rdy_rand = 1'b0;

    // expectation: {drop, is_db, addr, data}; tag = requirement number
    logic [97:0] exp_q [$];
    int          tag_q [$];

    task automatic check(input logic ok, input string req, input logic [97:0] act, input logic [97:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic logic [97:0] expect_of(input logic [OFF_W-1:0] off, input logic [31:0] d, output int tag);
        logic [OFF_W-1:0] rel;
        int idx;
        if (off < cfg_mw_off) begin
            idx = int'(off) / (1 << cfg_db_shift);
            if (!cfg_db_en) begin tag = 8; return {1'b1, 97'd0}; end
            if (idx >= int'(cfg_db_count)) begin tag = 5; return {1'b1, 97'd0}; end
            tag = 3;
            return {1'b0, 1'b1, db_addr[idx], db_dat[idx]};
        end
        rel = off - cfg_mw_off;
        if (!cfg_mw_en) begin tag = 8; return {1'b1, 97'd0}; end
        if (64'(rel) >= 64'(cfg_mw_size)) begin tag = 7; return {1'b1, 97'd0}; end
        tag = 6;
        return {1'b0, 1'b0, cfg_mw_base + 64'(rel), d};
    endfunction

    // downstream ready
    always @(posedge clk) begin
        #1;
        out_ready = rdy_rand ? ($urandom % 3 != 0) : 1'b1;
    end

    // monitor at the falling edge
    logic        pend = 1'b0;
    logic        was_hold = 1'b0;
    logic [96:0] held_v = '0;
    always @(negedge clk) begin
        logic [97:0] e;
        int t;
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
        if (!rst) begin
            if (pend)   // R9: result due one cycle after acceptance
                check(err_drop || out_valid, "R9", {96'd0, out_valid, err_drop}, 98'd1);
            if (was_hold)   // R10: held request unchanged
                check(out_valid && {out_is_db, out_addr, out_data} == held_v, "R10",
                      {out_valid, out_is_db, out_addr, out_data}, {1'b1, held_v});
            if (err_drop) begin
                if (exp_q.size() == 0) check(1'b0, "R9", 98'd1, 98'd0);
                else begin
                    e = exp_q.pop_front(); t = tag_q.pop_front();
                    check(e[97], $sformatf("R%0d", t), {1'b1, 97'd0}, e);
                end
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) check(1'b0, "R10", {1'b0, out_is_db, out_addr, out_data}, 98'd0);
                else begin
                    e = exp_q.pop_front(); t = tag_q.pop_front();
                    check(e == {1'b0, out_is_db, out_addr, out_data}, $sformatf("R%0d", t),
                          {1'b0, out_is_db, out_addr, out_data}, e);
                end
            end
            was_hold = out_valid && !out_ready;
            held_v   = {out_is_db, out_addr, out_data};
            pend = in_valid && in_ready;
            if (in_valid && in_ready) begin
                e = expect_of(in_off, in_data, t);
                exp_q.push_back(e);
                tag_q.push_back(t);
            end
        end
    end

    // called just after a rising edge
    task automatic send(input logic [OFF_W-1:0] off, input logic [31:0] d);
        in_valid = 1'b1; in_off = off; in_data = d;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin @(posedge clk); #1; end
        while (exp_q.size() != 0 || out_valid) begin @(posedge clk); #1; end
    endtask

    initial begin
        void'($urandom(32'd2718));
        // MSI style: one shared address, distinct data words
        for (int i = 0; i < NDB; i++) begin
            db_addr[i] = 64'h0000_0000_FEE0_0000;
            db_dat[i]  = 32'h40 + 32'(i) * 32'h11;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !err_drop, "R1", {96'd0, out_valid, err_drop}, 98'd0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(in_ready && !out_valid && !err_drop, "R1",
              {95'd0, in_ready, out_valid, err_drop}, 98'd4);
        @(posedge clk); #1;

        // R8: nothing configured yet
        send(20'h00008, 32'h1);
        send(20'h01010, 32'h2);
        drain();

        cfg_db_en = 1'b1; cfg_mw_en = 1'b1;
        @(posedge clk); #1;
        // R3/R4 shared address, input data ignored
        send(20'h00000, 32'hDEAD_0000);
        send(20'h0001C, 32'hDEAD_0001);   // R3 last configured doorbell (idx 7)
        send(20'h00020, 32'hDEAD_0002);   // R5 idx 8 == count
        send(20'h00FFF, 32'hDEAD_0003);   // R2/R5 last byte below split
        send(20'h01000, 32'h1111_2222);   // R2/R6 first window byte
        send(20'h017FF, 32'h3333_4444);   // R6 size-1
        send(20'h01800, 32'h5555_6666);   // R7 size
        drain();

        // MSI-X style: distinct addresses, 16-byte entries, full count
        for (int i = 0; i < NDB; i++)
            db_addr[i] = 64'h0000_0010_0000_0000 + 64'(i) * 64'h1000;
        cfg_db_shift = 5'd4; cfg_db_count = 6'd32;
        @(posedge clk); #1;
        send(20'h00013, 32'h0);   // R3 mid-entry rounds to idx 1
        send(20'h001F0, 32'h0);   // R4 idx 31
        send(20'h00200, 32'h0);   // R5 idx 32
        cfg_mw_en = 1'b0;
        @(posedge clk); #1;
        send(20'h01004, 32'h7);   // R8 window not configured
        drain();
        cfg_mw_en = 1'b1;

        // random phase with backpressure
        rdy_rand = 1'b1;
        for (int b = 0; b < 8; b++) begin
            cfg_db_shift = SH_W'(2 + $urandom % 3);
            cfg_db_count = CNT_W'($urandom % 33);
            cfg_mw_off   = OFF_W'((1 + $urandom % 8) * 32'h200);
            cfg_mw_size  = 32'h100 + ($urandom % 32'h800);
            cfg_mw_base  = {$urandom, $urandom};
            cfg_db_en    = ($urandom % 5) != 0;
            cfg_mw_en    = ($urandom % 5) != 0;
            for (int i = 0; i < NDB; i++) begin
                db_addr[i] = ((b % 2) == 0) ? 64'h0000_0000_FEE0_1000 : {$urandom, $urandom};
                db_dat[i]  = $urandom;
            end
            @(posedge clk); #1;
            for (int n = 0; n < 60; n++) begin
                send(OFF_W'($urandom % 32'h1A00), $urandom);
                if ($urandom % 4 == 0) begin @(posedge clk); #1; end
            end
            drain();
        end
        rdy_rand = 1'b0;
        drain();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule